// File: doc/BRIEF.md
# Run-time Selectable Memory Width Adapter

This block converts between a 32-bit application data port and a memory datapath whose width is picked at run time: 32, 16 or 8 bits. On the write path, the transfer controller strobes once for each memory beat it consumes. The block hands out the application word one slice at a time, least significant slice first, together with that slice's byte enables. It asks the application for a new word only when the current word has been used up or the burst ends.

On the read path, each memory beat that the transfer controller flags as valid is placed into the correct byte positions of a 32-bit word. The assembled word is presented with a valid strobe once it is complete, or early when the burst ends. Per-burst last flags pass through to the application on both paths. Separate start strobes for reads and writes put each path back on a word boundary.

Top module: `bus_width_adapter`

## Requirements
- R1: `width_sel_i` encodes the memory width: 2'b00 selects 32 bits (lanes 0..3), 2'b01 selects 16 bits (lanes 0..1) and 2'b1x selects 8 bits (lane 0). Lane k is bits 8k+7..8k. On writes, unused memory lanes carry zero data and enable 1 (disabled). On reads, unused memory lanes are ignored.
- R2: Each cycle with `xfer_wr_next_i` high captures the current slice of `app_wr_data_i`/`app_wr_be_ni` into `mem_wr_data_o`/`mem_wr_be_no`, visible after that clock edge. The lowest-addressed bytes go first, and successive strobes take successively higher slices. With `xfer_wr_next_i` low, both outputs hold their value.
- R3: `app_wr_next_o` is high, in the same cycle as `xfer_wr_next_i`, exactly when that strobe takes the final slice of the word or `xfer_wr_last_i` is high. The application advances to its next word on that edge.
- R4: `app_wr_last_o` equals `xfer_wr_next_i & xfer_wr_last_i` in the same cycle. A burst's last beat returns the write slice position to the first slice.
- R5: On each `xfer_rd_ok_i` beat, the used lanes of `mem_rd_data_i` land in the application bytes of the current slice, first beat in the least significant slice. `app_rd_valid_o` rises for one cycle, the cycle after the beat that completes the word, with the whole word on `app_rd_data_o`.
- R6: A read beat with `xfer_rd_last_i` high ends the word early. One cycle later, `app_rd_valid_o` and `app_rd_last_o` are both high, and the bytes of `app_rd_data_o` that were not filled in this burst are zero.
- R7: `xfer_wr_start_i` and `xfer_rd_start_i` each reset their own path's slice position to the first slice. This takes effect in the same cycle, so a beat strobed together with the start uses the least significant slice.
- R8: In 32-bit mode, every write strobe requests a new word. Memory write data equals the application word one clock later, and every read beat yields a valid word one clock later.
- R9: After reset, `app_rd_valid_o`, `app_rd_last_o`, `mem_wr_data_o` and `app_rd_data_o` are zero, and `mem_wr_be_no` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Memory width select (00=32, 01=16, 1x=8) |
| xfer_wr_start_i | input | 1 | Write burst start from transfer controller |
| xfer_wr_next_i | input | 1 | Transfer controller consumes one write beat |
| xfer_wr_last_i | input | 1 | Current write beat is the last of the burst |
| app_wr_data_i | input | 32 | Application write word |
| app_wr_be_ni | input | 4 | Application byte write enables, active low |
| app_wr_next_o | output | 1 | Application word consumed, present the next |
| app_wr_last_o | output | 1 | Final write transfer of the burst |
| mem_wr_data_o | output | 32 | Write beat toward memory |
| mem_wr_be_no | output | 4 | Write beat byte enables, active low |
| xfer_rd_start_i | input | 1 | Read burst start from transfer controller |
| xfer_rd_ok_i | input | 1 | Read beat valid on mem_rd_data_i |
| xfer_rd_last_i | input | 1 | Current read beat is the last of the burst |
| mem_rd_data_i | input | 32 | Read beat from memory |
| app_rd_data_o | output | 32 | Packed read word |
| app_rd_valid_o | output | 1 | Packed read word valid |
| app_rd_last_o | output | 1 | Final read word of the burst |

## Verification
The assertions assume that `width_sel_i` is steady for the whole of a burst. They also assume that the transfer controller strobes last only together with a next or ok beat. Under these assumptions, the lane, hold and pass-through properties depend only on the current select value and the strobes.

The stimulus changes the width only between bursts. It raises the last flag only on a burst's final beat. It inserts idle cycles in which the strobes are low but the application data changes, so the hold behaviour is exercised against moving inputs. Some bursts are preceded by stray beats that leave the slice position in the middle of a word; the following start strobe must clear it.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int BYTE_W    = 8;
  localparam int APP_BYTES = 4;
  localparam int APP_DW    = APP_BYTES * BYTE_W;
  localparam int IDX_W     = $clog2(APP_BYTES);

  // log2 of bytes per memory beat
  function automatic logic [1:0] beat_lg(input logic [1:0] sel);
    if (sel[1])      return 2'd0;
    else if (sel[0]) return 2'd1;
    else             return 2'd2;
  endfunction

  function automatic logic [IDX_W-1:0] final_idx(input logic [1:0] sel);
    return IDX_W'((APP_BYTES - 1) >> beat_lg(sel));
  endfunction
endpackage

// File: rtl/bwa_slice_ctr.sv
module bwa_slice_ctr #(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             close_i,
  input  logic [IDX_W-1:0] final_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             final_o
);
  logic [IDX_W-1:0] cnt_q;

  assign idx_o   = start_i ? '0 : cnt_q;
  assign final_o = (idx_o == final_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (step_i && (final_o || close_i)) cnt_q <= '0;
    else if (step_i)                   cnt_q <= idx_o + 1'b1;
    else                               cnt_q <= idx_o;
  end
endmodule

// File: rtl/bwa_wr_split.sv
module bwa_wr_split #(
  parameter int BYTE_W    = 8,
  parameter int APP_BYTES = 4,
  localparam int IDX_W    = $clog2(APP_BYTES),
  localparam int DW       = APP_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           lg_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 step_i,
  input  logic [DW-1:0]        app_data_i,
  input  logic [APP_BYTES-1:0] app_be_ni,
  output logic [DW-1:0]        mem_data_o,
  output logic [APP_BYTES-1:0] mem_be_no
);
  logic [IDX_W:0]         bpb;
  logic [DW-1:0]          data_d;
  logic [APP_BYTES-1:0]   be_d;

  assign bpb = (IDX_W+1)'(1) << lg_i;

  for (genvar k = 0; k < APP_BYTES; k++) begin : g_lane
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(idx_i << lg_i) + IDX_W'(k);
    always_comb begin
      if ((IDX_W+1)'(k) < bpb) begin
        data_d[k*BYTE_W +: BYTE_W] = app_data_i[src*BYTE_W +: BYTE_W];
        be_d[k]                    = app_be_ni[src];
      end else begin
        data_d[k*BYTE_W +: BYTE_W] = '0;
        be_d[k]                    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_data_o <= '0;
      mem_be_no  <= '1;
    end else if (step_i) begin
      mem_data_o <= data_d;
      mem_be_no  <= be_d;
    end
  end
endmodule

// File: rtl/bwa_rd_pack.sv
module bwa_rd_pack #(
  parameter int BYTE_W    = 8,
  parameter int APP_BYTES = 4,
  localparam int IDX_W    = $clog2(APP_BYTES),
  localparam int DW       = APP_BYTES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       lg_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             final_i,
  input  logic             step_i,
  input  logic             close_i,
  input  logic [DW-1:0]    mem_data_i,
  output logic [DW-1:0]    app_data_o,
  output logic             app_valid_o,
  output logic             app_last_o
);
  logic [IDX_W:0] bpb;
  assign bpb = (IDX_W+1)'(1) << lg_i;

  for (genvar j = 0; j < APP_BYTES; j++) begin : g_byte
    logic [IDX_W-1:0] tgt, lane;
    assign tgt  = IDX_W'(IDX_W'(j) >> lg_i);
    assign lane = IDX_W'(j) & IDX_W'(bpb - 1'b1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        app_data_o[j*BYTE_W +: BYTE_W] <= '0;
      else if (step_i && tgt == idx_i)
        app_data_o[j*BYTE_W +: BYTE_W] <= mem_data_i[lane*BYTE_W +: BYTE_W];
      else if (step_i && idx_i == '0)
        app_data_o[j*BYTE_W +: BYTE_W] <= '0;  // fresh word: clear unfilled bytes
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_valid_o <= 1'b0;
      app_last_o  <= 1'b0;
    end else begin
      app_valid_o <= step_i && (final_i || close_i);
      app_last_o  <= step_i && close_i;
    end
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int BYTE_W_P    = BYTE_W,
  parameter int APP_BYTES_P = APP_BYTES,
  localparam int DW         = BYTE_W_P * APP_BYTES_P,
  localparam int IW         = $clog2(APP_BYTES_P)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             width_sel_i,
  input  logic                   xfer_wr_start_i,
  input  logic                   xfer_wr_next_i,
  input  logic                   xfer_wr_last_i,
  input  logic [DW-1:0]          app_wr_data_i,
  input  logic [APP_BYTES_P-1:0] app_wr_be_ni,
  output logic                   app_wr_next_o,
  output logic                   app_wr_last_o,
  output logic [DW-1:0]          mem_wr_data_o,
  output logic [APP_BYTES_P-1:0] mem_wr_be_no,
  input  logic                   xfer_rd_start_i,
  input  logic                   xfer_rd_ok_i,
  input  logic                   xfer_rd_last_i,
  input  logic [DW-1:0]          mem_rd_data_i,
  output logic [DW-1:0]          app_rd_data_o,
  output logic                   app_rd_valid_o,
  output logic                   app_rd_last_o
);
  logic [1:0]    lg;
  logic [IW-1:0] fin_idx, wr_idx, rd_idx;
  logic          wr_final, rd_final;

  assign lg      = beat_lg(width_sel_i);
  assign fin_idx = IW'(final_idx(width_sel_i));

  bwa_slice_ctr #(.IDX_W(IW)) u_wr_ctr (
    .clk_i, .rst_ni,
    .start_i     (xfer_wr_start_i),
    .step_i      (xfer_wr_next_i),
    .close_i     (xfer_wr_last_i),
    .final_idx_i (fin_idx),
    .idx_o       (wr_idx),
    .final_o     (wr_final)
  );

  bwa_slice_ctr #(.IDX_W(IW)) u_rd_ctr (
    .clk_i, .rst_ni,
    .start_i     (xfer_rd_start_i),
    .step_i      (xfer_rd_ok_i),
    .close_i     (xfer_rd_last_i),
    .final_idx_i (fin_idx),
    .idx_o       (rd_idx),
    .final_o     (rd_final)
  );

  bwa_wr_split #(.BYTE_W(BYTE_W_P), .APP_BYTES(APP_BYTES_P)) u_split (
    .clk_i, .rst_ni,
    .lg_i       (lg),
    .idx_i      (wr_idx),
    .step_i     (xfer_wr_next_i),
    .app_data_i (app_wr_data_i),
    .app_be_ni  (app_wr_be_ni),
    .mem_data_o (mem_wr_data_o),
    .mem_be_no  (mem_wr_be_no)
  );

  bwa_rd_pack #(.BYTE_W(BYTE_W_P), .APP_BYTES(APP_BYTES_P)) u_pack (
    .clk_i, .rst_ni,
    .lg_i        (lg),
    .idx_i       (rd_idx),
    .final_i     (rd_final),
    .step_i      (xfer_rd_ok_i),
    .close_i     (xfer_rd_last_i),
    .mem_data_i  (mem_rd_data_i),
    .app_data_o  (app_rd_data_o),
    .app_valid_o (app_rd_valid_o),
    .app_last_o  (app_rd_last_o)
  );

  assign app_wr_next_o = xfer_wr_next_i && (wr_final || xfer_wr_last_i);
  assign app_wr_last_o = xfer_wr_next_i && xfer_wr_last_i;
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  width_sel_i,
  input logic        xfer_wr_next_i,
  input logic [31:0] app_wr_data_i,
  input logic        app_wr_next_o,
  input logic        app_wr_last_o,
  input logic [31:0] mem_wr_data_o,
  input logic [3:0]  mem_wr_be_no,
  input logic        xfer_rd_ok_i,
  input logic        app_rd_valid_o,
  input logic        app_rd_last_o
);
  assert_lane8_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_wr_next_i && width_sel_i[1]) |=> (mem_wr_be_no[3:1] == 3'b111 && mem_wr_data_o[31:8] == '0));

  assert_lane16_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_wr_next_i && width_sel_i == 2'b01) |=> (mem_wr_be_no[3:2] == 2'b11 && mem_wr_data_o[31:16] == '0));

  assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_wr_next_i |=> ($stable(mem_wr_data_o) && $stable(mem_wr_be_no)));

  assert_next_needs_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_next_o |-> xfer_wr_next_i);

  assert_wr_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_last_o |-> app_wr_next_o);

  assert_rd_valid_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_valid_o |-> $past(xfer_rd_ok_i));

  assert_rd_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_last_o |-> app_rd_valid_o);

  assert_pass32_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_wr_next_i && width_sel_i == 2'b00) |=> mem_wr_data_o == $past(app_wr_data_i));

  assert_next32_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_wr_next_i && width_sel_i == 2'b00) |-> app_wr_next_o);
endmodule

bind bus_width_adapter bwa_checker u_bwa_checker (
  .clk_i, .rst_ni, .width_sel_i, .xfer_wr_next_i, .app_wr_data_i,
  .app_wr_next_o, .app_wr_last_o, .mem_wr_data_o, .mem_wr_be_no,
  .xfer_rd_ok_i, .app_rd_valid_o, .app_rd_last_o
);

// File: tb/bus_width_adapter_tb_top.sv
`timescale 1ns/1ps
module bus_width_adapter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  width_sel_i = '0;
  logic        xfer_wr_start_i = 0, xfer_wr_next_i = 0, xfer_wr_last_i = 0;
  logic [31:0] app_wr_data_i = '0;
  logic [3:0]  app_wr_be_ni = '1;
  logic        app_wr_next_o, app_wr_last_o;
  logic [31:0] mem_wr_data_o;
  logic [3:0]  mem_wr_be_no;
  logic        xfer_rd_start_i = 0, xfer_rd_ok_i = 0, xfer_rd_last_i = 0;
  logic [31:0] mem_rd_data_i = '0;
  logic [31:0] app_rd_data_o;
  logic        app_rd_valid_o, app_rd_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bus_width_adapter dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bytes_per(input logic [1:0] sel);
    return sel[1] ? 1 : (sel[0] ? 2 : 4);
  endfunction

  function automatic logic [31:0] word_val(input logic [1:0] sel, input int w);
    return (32'h9E3779B9 * 32'(w + 3)) ^ (32'(sel) * 32'h01234567);
  endfunction

  function automatic logic [3:0] word_be(input logic [1:0] sel, input int w);
    return 4'((w * 7 + int'(sel) * 3) & 15);
  endfunction

  // write burst of n memory beats, preceded by 'stray' beats without start
  task automatic wr_burst(input logic [1:0] sel, input int n, input int stray);
    int bpb = bytes_per(sel);
    int spb = 4 / bpb;
    logic [31:0] ed;
    logic [3:0]  eb;
    width_sel_i = sel;
    for (int t = 0; t < stray; t++) begin
      @(negedge clk_i);
      xfer_wr_next_i = 1; xfer_wr_last_i = 0; xfer_wr_start_i = 0;
      app_wr_data_i = 32'hDEADBEEF; app_wr_be_ni = 4'h0;
    end
    for (int s = 0; s < n; s++) begin
      int sl = s % spb;
      int w  = s / spb;
      bit lst = (s == n - 1);
      @(negedge clk_i);
      xfer_wr_start_i = (s == 0);
      xfer_wr_next_i  = 1;
      xfer_wr_last_i  = lst;
      app_wr_data_i   = word_val(sel, w);
      app_wr_be_ni    = word_be(sel, w);
      #1;
      chk(app_wr_next_o == ((sl == spb - 1) || lst), (sel == 0) ? "R8 wr_next" : "R3 wr_next",
          32'(app_wr_next_o), 32'((sl == spb - 1) || lst));
      chk(app_wr_last_o == lst, "R4 wr_last", 32'(app_wr_last_o), 32'(lst));
      ed = '0; eb = '1;
      for (int k = 0; k < bpb; k++) begin
        ed[k*8 +: 8] = app_wr_data_i[(sl*bpb + k)*8 +: 8];
        eb[k]        = app_wr_be_ni[sl*bpb + k];
      end
      @(posedge clk_i); #1;
      chk(mem_wr_data_o == ed, (s == 0 && stray > 0) ? "R7 wr data" : "R1 R2 wr data", mem_wr_data_o, ed);
      chk(mem_wr_be_no == eb, "R1 R2 wr be", 32'(mem_wr_be_no), 32'(eb));
      if (s % 3 == 1) begin
        @(negedge clk_i);
        xfer_wr_next_i = 0; xfer_wr_last_i = 0; xfer_wr_start_i = 0;
        app_wr_data_i = ~app_wr_data_i; app_wr_be_ni = ~app_wr_be_ni;
        #1;
        chk(app_wr_next_o == 0, "R3 idle no next", 32'(app_wr_next_o), 0);
        @(posedge clk_i); #1;
        chk(mem_wr_data_o == ed && mem_wr_be_no == eb, "R2 hold", mem_wr_data_o, ed);
      end
    end
    @(negedge clk_i);
    xfer_wr_next_i = 0; xfer_wr_last_i = 0; xfer_wr_start_i = 0;
  endtask

  task automatic rd_burst(input logic [1:0] sel, input int n, input int stray);
    int bpb = bytes_per(sel);
    int spb = 4 / bpb;
    logic [31:0] exp_w = '0;
    width_sel_i = sel;
    for (int t = 0; t < stray; t++) begin
      @(negedge clk_i);
      xfer_rd_ok_i = 1; xfer_rd_last_i = 0; xfer_rd_start_i = 0;
      mem_rd_data_i = 32'hCAFEF00D;
    end
    for (int s = 0; s < n; s++) begin
      int sl = s % spb;
      bit lst = (s == n - 1);
      bit ev  = (sl == spb - 1) || lst;
      @(negedge clk_i);
      xfer_rd_start_i = (s == 0);
      xfer_rd_ok_i    = 1;
      xfer_rd_last_i  = lst;
      mem_rd_data_i   = word_val(~sel, s + 11);
      if (sl == 0) exp_w = '0;
      for (int k = 0; k < bpb; k++)
        exp_w[(sl*bpb + k)*8 +: 8] = mem_rd_data_i[k*8 +: 8];
      @(posedge clk_i); #1;
      chk(app_rd_valid_o == ev, (sel == 0) ? "R8 rd valid" : "R5 rd valid", 32'(app_rd_valid_o), 32'(ev));
      chk(app_rd_last_o == lst, "R6 rd last", 32'(app_rd_last_o), 32'(lst));
      if (ev)
        chk(app_rd_data_o == exp_w, lst ? "R6 rd data" : ((stray > 0) ? "R7 rd data" : "R1 R5 rd data"),
            app_rd_data_o, exp_w);
      if (s % 4 == 2) begin
        @(negedge clk_i);
        xfer_rd_ok_i = 0; xfer_rd_last_i = 0; xfer_rd_start_i = 0;
        mem_rd_data_i = 32'h5A5A5A5A;
        @(posedge clk_i); #1;
        chk(app_rd_valid_o == 0, "R5 idle no valid", 32'(app_rd_valid_o), 0);
      end
    end
    @(negedge clk_i);
    xfer_rd_ok_i = 0; xfer_rd_last_i = 0; xfer_rd_start_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(app_rd_valid_o == 0 && app_rd_last_o == 0, "R9 reset valid", 32'(app_rd_valid_o), 0);
    chk(mem_wr_data_o == 0, "R9 reset wr data", mem_wr_data_o, 0);
    chk(mem_wr_be_no == 4'hF, "R9 reset wr be", 32'(mem_wr_be_no), 32'hF);
    chk(app_rd_data_o == 0, "R9 reset rd data", app_rd_data_o, 0);
    @(negedge clk_i); rst_ni = 1;
    for (int sel = 0; sel < 4; sel++)
      for (int n = 1; n <= 9; n++) begin
        wr_burst(2'(sel), n, 0);
        rd_burst(2'(sel), n, 0);
        if (n % 2 == 1) begin
          wr_burst(2'(sel), n, 1 + (n % 3));
          rd_burst(2'(sel), n, 1 + (n % 3));
        end
      end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule